// File: doc/BRIEF.md
# Disk Controller Output Control Register

This block is the 8-bit output control register of a disk interface controller. A host writes and reads it through a simple address-decoded register port. The stored byte has four jobs. It picks one of four drives through one-hot select lines. It switches four spindle motor outputs. It holds the controller core in software reset. It decides whether the DMA request, DMA acknowledge, terminal count and interrupt signals are live.

The software reset is level-held: the core stays in reset while the reset-release bit is 0. A counter stretches the reset so that it always lasts a minimum number of clock cycles. This holds even when the host clears the bit and sets it again on the very next write. The core reset never alters the register itself.

The DMA and interrupt gating depends on a mode pin. In the legacy mode, the DMA-enable bit controls the four signals. In the alternate mode, they are always live. Floating is expressed as output-enable signals for the pads. Disabled inputs are masked to their inactive levels. The register port carries no data stream, so there is no valid/ready handshake and no back-pressure: every access completes in the cycle it is presented.

Top module: `dsk_ctl_reg`

## Requirements
- R1: The register responds only at address REG_ADDR (default 0x3F2). A write there stores host_wdata at the next clock edge. A read there returns the stored byte combinationally, exactly as last written. A read at any other address returns 0x00, and a write at any other address leaves the stored byte unchanged.
- R2: Bits 1:0 hold a binary drive number n, and drv_sel has exactly one bit set, bit n.
- R3: Bits 7:4 drive motor_on[3:0], so bit 4+i set makes motor_on[i] high.
- R4: While bit 2 holds 0, core_rst is high, and it stays high until a 1 is written to bit 2. Clearing bit 2 changes no other bit of the register, and the stored byte reads back unchanged while core_rst is asserted.
- R5: After bit 2 is written to 0, core_rst stays high for at least RST_CYC clock cycles, even when the next write sets bit 2 again. For a 0 write at edge k followed by a 1 write at edge k+1, core_rst is high for exactly RST_CYC cycles.
- R6: With mode_alt=0 and bit 3=1, dma_req_oe and irq_oe are 1, and core_dma_ack_n and core_tc follow dma_ack_n and tc. dma_req and irq always follow core_dma_req and core_irq, and only the enables decide whether the pads float.
- R7: With mode_alt=0 and bit 3=0, dma_req_oe and irq_oe are 0, core_dma_ack_n is held at 1 (inactive), and core_tc is held at 0.
- R8: With mode_alt=1, the four signals are enabled whatever bit 3 holds. Bit 3 still stores and reads back normally, and a hardware reset still clears it.
- R9: After hardware reset (rst_n low), all eight register bits are 0. So drv_sel=0001, motor_on=0000 and core_rst=1, and in legacy mode the DMA and interrupt enables are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| host_addr | input | ADDR_W | Host I/O address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (0x00 when not addressed) |
| mode_alt | input | 1 | 1 = alternate mode, DMA and interrupt signals always enabled |
| drv_sel | output | 4 | One-hot drive select |
| motor_on | output | 4 | Motor enable outputs |
| core_rst | output | 1 | Stretched reset to the controller core, active high |
| core_dma_req | input | 1 | DMA request from the core |
| core_irq | input | 1 | Interrupt from the core |
| dma_req | output | 1 | DMA request toward the pad |
| dma_req_oe | output | 1 | Output enable of the DMA request pad |
| irq | output | 1 | Interrupt toward the pad |
| irq_oe | output | 1 | Output enable of the interrupt pad |
| dma_ack_n | input | 1 | DMA acknowledge from the pad, active low |
| tc | input | 1 | Terminal count from the pad |
| core_dma_ack_n | output | 1 | Gated acknowledge to the core |
| core_tc | output | 1 | Gated terminal count to the core |

## Verification
The bench builds the block with its default parameters: ADDR_W=10, REG_ADDR=0x3F2 and RST_CYC=20, which is 100 ns at a 200 MHz clock. The full 20-cycle stretch is therefore measured edge by edge after a 0-then-1 write pair, next to a long held reset that outlasts it. The neighbouring address 0x3F3 sits within one bit of the register's own address, so it probes the decode for both reads and writes.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int DRV_N = 4;
  localparam int MOT_N = 4;
  localparam int DRV_W = $clog2(DRV_N);

  // Bit layout of the stored byte: [7:4] motors, [3] dma enable,
  // [2] core run (0 holds reset), [1:0] drive number.
  typedef struct packed {
    logic [MOT_N-1:0] mot;
    logic             dma_en;
    logic             run;
    logic [DRV_W-1:0] drv;
  } ctl_byte_t;
endpackage

// File: rtl/dcr_host_reg.sv
module dcr_host_reg
  import dcr_pkg::*;
#(
  parameter int              ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] REG_ADDR = 10'h3F2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output ctl_byte_t         ctl_q
);
  logic hit;
  assign hit = (addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (wr && hit) ctl_q <= ctl_byte_t'(wdata);
  end

  // Readback is the stored byte, never the live pin state.
  assign rdata = (rd && hit) ? 8'(ctl_q) : 8'h00;
endmodule

// File: rtl/dcr_rst_stretch.sv
module dcr_rst_stretch #(
  parameter int RST_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic core_rst
);
  localparam int CW = (RST_CYC > 1) ? $clog2(RST_CYC + 1) : 1;
  localparam logic [CW-1:0] LOAD = CW'(RST_CYC - 1);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_cnt <= '0;
    else if (!run)           hold_cnt <= LOAD;
    else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
  end

  assign core_rst = !run || (hold_cnt != '0);
endmodule

// File: rtl/dcr_pin_gate.sv
module dcr_pin_gate
  import dcr_pkg::*;
(
  input  logic             mode_alt,
  input  ctl_byte_t        ctl,
  output logic [DRV_N-1:0] drv_sel,
  output logic [MOT_N-1:0] motor_on,
  input  logic             core_dma_req,
  input  logic             core_irq,
  output logic             dma_req,
  output logic             dma_req_oe,
  output logic             irq,
  output logic             irq_oe,
  input  logic             dma_ack_n,
  input  logic             tc,
  output logic             core_dma_ack_n,
  output logic             core_tc
);
  logic live;
  assign live = mode_alt || ctl.dma_en;

  for (genvar i = 0; i < DRV_N; i++) begin : g_dsel
    assign drv_sel[i] = (ctl.drv == DRV_W'(i));
  end

  for (genvar j = 0; j < MOT_N; j++) begin : g_mot
    assign motor_on[j] = ctl.mot[j];
  end

  assign dma_req        = core_dma_req;
  assign irq            = core_irq;
  assign dma_req_oe     = live;
  assign irq_oe         = live;
  assign core_dma_ack_n = live ? dma_ack_n : 1'b1;
  assign core_tc        = live ? tc : 1'b0;
endmodule

// File: rtl/dsk_ctl_reg.sv
module dsk_ctl_reg
  import dcr_pkg::*;
#(
  parameter int              ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] REG_ADDR = 10'h3F2,
  parameter int              RST_CYC  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              mode_alt,
  output logic [3:0]        drv_sel,
  output logic [3:0]        motor_on,
  output logic              core_rst,
  input  logic              core_dma_req,
  input  logic              core_irq,
  output logic              dma_req,
  output logic              dma_req_oe,
  output logic              irq,
  output logic              irq_oe,
  input  logic              dma_ack_n,
  input  logic              tc,
  output logic              core_dma_ack_n,
  output logic              core_tc
);
  ctl_byte_t ctl_q;

  dcr_host_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (host_addr),
    .wr    (host_wr),
    .rd    (host_rd),
    .wdata (host_wdata),
    .rdata (host_rdata),
    .ctl_q (ctl_q)
  );

  dcr_rst_stretch #(.RST_CYC(RST_CYC)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctl_q.run),
    .core_rst (core_rst)
  );

  dcr_pin_gate u_gate (
    .mode_alt       (mode_alt),
    .ctl            (ctl_q),
    .drv_sel        (drv_sel),
    .motor_on       (motor_on),
    .core_dma_req   (core_dma_req),
    .core_irq       (core_irq),
    .dma_req        (dma_req),
    .dma_req_oe     (dma_req_oe),
    .irq            (irq),
    .irq_oe         (irq_oe),
    .dma_ack_n      (dma_ack_n),
    .tc             (tc),
    .core_dma_ack_n (core_dma_ack_n),
    .core_tc        (core_tc)
  );
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker #(
  parameter int              ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] REG_ADDR = 10'h3F2,
  parameter int              RST_CYC  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic [7:0]        host_wdata,
  input logic              mode_alt,
  input logic [3:0]        drv_sel,
  input logic              core_rst,
  input logic              dma_req_oe,
  input logic              irq_oe,
  input logic              core_dma_ack_n,
  input logic              core_tc,
  input logic [7:0]        ctl_bits
);
  localparam int HW = $clog2(RST_CYC + 1) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   hi_cnt <= '0;
    else if (!core_rst)           hi_cnt <= '0;
    else if (hi_cnt != {HW{1'b1}}) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr == REG_ADDR) |=> $stable(ctl_bits));

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(drv_sel) == 1);

  assert_sw_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == REG_ADDR && !host_wdata[2]) |=> core_rst);

  assert_min_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> (hi_cnt >= HW'(RST_CYC)));

  assert_legacy_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_alt && !ctl_bits[3]) |-> (!dma_req_oe && !irq_oe && core_dma_ack_n && !core_tc));

  assert_alt_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_alt |-> (dma_req_oe && irq_oe));
endmodule

bind dsk_ctl_reg dcr_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .RST_CYC(RST_CYC)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_addr      (host_addr),
  .host_wr        (host_wr),
  .host_wdata     (host_wdata),
  .mode_alt       (mode_alt),
  .drv_sel        (drv_sel),
  .core_rst       (core_rst),
  .dma_req_oe     (dma_req_oe),
  .irq_oe         (irq_oe),
  .core_dma_ack_n (core_dma_ack_n),
  .core_tc        (core_tc),
  .ctl_bits       (8'(ctl_q))
);

// File: tb/dsk_ctl_reg_test.sv
`timescale 1ns/1ps
module dsk_ctl_reg_test;
  localparam int ADDR_W = 10;
  localparam logic [ADDR_W-1:0] RA = 10'h3F2;
  localparam int RST_CYC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic mode_alt = 1'b0;
  logic [3:0] drv_sel, motor_on;
  logic core_rst, core_dma_req = 1'b0, core_irq = 1'b0;
  logic dma_req, dma_req_oe, irq, irq_oe;
  logic dma_ack_n = 1'b1, tc = 1'b0;
  logic core_dma_ack_n, core_tc;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dsk_ctl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(RA), .RST_CYC(RST_CYC)) uut (.*);

  // {mode_alt, wdata, exp drv_sel, exp motor_on, exp enable}
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 8'h1C, 4'b0001, 4'b0001, 1'b1},
    {1'b0, 8'h25, 4'b0010, 4'b0010, 1'b0},
    {1'b0, 8'h4E, 4'b0100, 4'b0100, 1'b1},
    {1'b0, 8'h87, 4'b1000, 4'b1000, 1'b0},
    {1'b1, 8'hF7, 4'b1000, 4'b1111, 1'b1},
    {1'b1, 8'h04, 4'b0001, 4'b0000, 1'b1},
    {1'b1, 8'hAD, 4'b0010, 4'b1010, 1'b1},
    {1'b0, 8'h56, 4'b0100, 4'b0101, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    host_addr = a; host_rd = 1'b1;
    #0.5 d = host_rdata;
    host_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int hi;
    repeat (3) @(negedge clk);
    // R9 reset state
    rd(RA, r);
    chk(r == 8'h00, "R9 rdata", r, 0);
    chk(drv_sel == 4'b0001, "R9 drv_sel", drv_sel, 1);
    chk(motor_on == 4'b0000, "R9 motor_on", motor_on, 0);
    chk(core_rst == 1'b1, "R9 core_rst", core_rst, 1);
    chk(!dma_req_oe && !irq_oe, "R9 enables", {dma_req_oe, irq_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(core_rst == 1'b1, "R9 core_rst after release", core_rst, 1);

    // Vector walk: R1 R2 R3 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      mode_alt = VEC[i][17];
      wr(RA, VEC[i][16:9]);
      dma_ack_n = 1'b0; tc = 1'b1; core_dma_req = i[0]; core_irq = ~i[0];
      rd(RA, r);
      chk(r == VEC[i][16:9], "R1 readback", r, VEC[i][16:9]);
      chk(drv_sel == VEC[i][8:5], "R2 drv_sel", drv_sel, VEC[i][8:5]);
      chk(motor_on == VEC[i][4:1], "R3 motor_on", motor_on, VEC[i][4:1]);
      chk(dma_req_oe == VEC[i][0] && irq_oe == VEC[i][0], "R6 R7 R8 oe",
          {dma_req_oe, irq_oe}, {2{VEC[i][0]}});
      chk(core_dma_ack_n == !VEC[i][0] && core_tc == VEC[i][0], "R6 R7 R8 input mask",
          {core_dma_ack_n, core_tc}, {!VEC[i][0], VEC[i][0]});
      chk(dma_req == i[0] && irq == ~i[0], "R6 pass-through", {dma_req, irq}, {i[0], ~i[0]});
      dma_ack_n = 1'b1; tc = 1'b0;
    end

    // R8: bit 3 still stored in alternate mode, cleared by hardware reset
    mode_alt = 1'b1;
    wr(RA, 8'h0C);
    rd(RA, r);
    chk(r == 8'h0C, "R8 bit3 stored", r, 8'h0C);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(RA, r);
    chk(r == 8'h00, "R8 R9 cleared by reset", r, 0);
    chk(dma_req_oe && irq_oe, "R8 enabled through reset", {dma_req_oe, irq_oe}, 2'b11);
    mode_alt = 1'b0;

    // R1 other address
    wr(RA, 8'h1D);
    wr(RA + 1'b1, 8'hFF);
    rd(RA, r);
    chk(r == 8'h1D, "R1 foreign write ignored", r, 8'h1D);
    rd(RA + 1'b1, r);
    chk(r == 8'h00, "R1 foreign read", r, 0);
    chk(drv_sel == 4'b0010, "R1 drv unchanged", drv_sel, 4'b0010);

    // R4 long hold
    repeat (RST_CYC + 2) @(negedge clk);
    chk(core_rst == 1'b0, "R4 released", core_rst, 0);
    wr(RA, 8'hB9);
    repeat (3 * RST_CYC) @(negedge clk);
    chk(core_rst == 1'b1, "R4 held", core_rst, 1);
    rd(RA, r);
    chk(r == 8'hB9, "R4 bits intact", r, 8'hB9);
    chk(motor_on == 4'b1011 && drv_sel == 4'b0010, "R4 outputs intact",
        {motor_on, drv_sel}, {4'b1011, 4'b0010});
    wr(RA, 8'hBD);
    repeat (RST_CYC + 1) @(negedge clk);
    chk(core_rst == 1'b0, "R4 released by 1", core_rst, 0);

    // R5 back-to-back 0 then 1
    wr(RA, 8'h18);
    hi = core_rst ? 1 : 0;
    host_addr = RA; host_wdata = 8'h1C; host_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0;
    for (int k = 0; k < 4 * RST_CYC; k++) begin
      if (!core_rst) break;
      hi++;
      @(negedge clk);
    end
    chk(hi == RST_CYC, "R5 stretch width", hi, RST_CYC);
    rd(RA, r);
    chk(r == 8'h1C, "R5 R4 readback", r, 8'h1C);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule